// File: doc/BRIEF.md
# Single-Cycle Word-Oriented Integer Core

This block is a small 32-bit processor core. Every clock it executes one instruction. It fetches one 32-bit word from a combinational instruction port at the program counter, then decodes and executes it. The result is written back on the same clock edge that advances the program counter. The core covers a handful of operations:

- register add and subtract, each of which flags signed overflow;
- a shift left by a constant amount;
- add with a sign-extended immediate;
- OR with a zero-extended immediate;
- load of an upper half-word;
- word load and word store, each addressed as base register plus signed offset.

The subset is enough to build any 32-bit constant, compute on registers and move words to and from a data port. There is no branch or jump, so the core runs straight-line code from address zero after reset. The register file has 32 entries, and entry zero is a constant zero. The data port is combinational on the read side and written on the clock edge when the write strobe is high.

Top module: `mini_core`

## Requirements
- R1: With opcode 0 (bits 31..26), funct 32 (bits 5..0) writes rs+rt and funct 34 writes rs-rt, modulo 2^32. The destination is rd (bits 15..11), with rs in bits 25..21 and rt in bits 20..16. The word 0x01095020 writes reg8+reg9 into reg10.
- R2: Opcode 0 with funct 0 writes rt shifted left by shamt (bits 10..6) into rd, with zeros filled in from the right. The word 0x00084080 writes reg8<<2 into reg8.
- R3: Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits 15..0) into rt. The word 0x21090001 writes reg8+1 into reg9.
- R4: Opcode 13 writes rs OR the zero-extended 16-bit immediate into rt.
- R5: Opcode 15 writes the immediate into bits 31..16 of rt and clears bits 15..0. The rs field is ignored.
- R6: Opcode 35 loads the data word at rs + sign-extended offset into rt. Opcode 43 stores rt to that same address. Only a store raises the data write strobe, and a load leaves data memory unchanged.
- R7: Register 0 always reads as zero. Any instruction that targets it leaves it at zero.
- R8: A synchronous reset sets the program counter to 0 and keeps the write strobe low. After reset the counter advances by 4 on every clock.
- R9: The overflow output is high while an add, subtract or add-immediate overflows in two's complement. The wrapped result is still written back, and other instructions keep the output low.
- R10: Any other opcode, or any other funct under opcode 0, raises the illegal output for that cycle. Such an instruction writes no register and no memory, and the program counter still advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch address (the program counter) |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data address, base register plus signed offset |
| dmem_wdata | output | 32 | Data word to store |
| dmem_we | output | 1 | Data write strobe, high only for a store |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |
| ovf | output | 1 | Signed overflow of the current add, subtract or add-immediate |
| illegal | output | 1 | Current instruction is not in the supported subset |

## Verification
The bench builds the core with its default parameters. The word width is 32, there are 32 registers, the counter step is 4, the reset address is 0, and register zero has no storage. With these values the fixed encoding can be driven directly, including the literal instruction words listed in the requirements. The bench runs short programs from a reset start and observes register contents only through stores to its own data memory. This makes back-to-back use of a just-loaded value, the two immediate extensions, a negative load offset, and writes aimed at register zero all visible at the ports. Overflow and illegal flags are logged per fetch address, so each offending instruction can be singled out from its neighbours.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;

   localparam logic [5:0] OPC_REG   = 6'd0;
   localparam logic [5:0] OPC_ADDI  = 6'd8;
   localparam logic [5:0] OPC_ORI   = 6'd13;
   localparam logic [5:0] OPC_LUI   = 6'd15;
   localparam logic [5:0] OPC_LOAD  = 6'd35;
   localparam logic [5:0] OPC_STORE = 6'd43;

   localparam logic [5:0] FN_SLL = 6'd0;
   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_SLL = 3'd2,
      ALU_OR  = 3'd3,
      ALU_LUI = 3'd4
   } alu_op_e;

   typedef struct packed {
      alu_op_e    alu_op;
      logic       b_imm;     // second operand is the extended immediate
      logic       imm_zext;  // zero- rather than sign-extend
      logic       rf_we;
      logic       wb_mem;    // writeback from data port
      logic [4:0] dst;
      logic       mem_we;
      logic       ovf_en;
      logic       illegal;
   } ctl_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
   import mini_core_pkg::*;
(
   input  logic [31:0] instr,
   output ctl_t        ctl
);

   logic [5:0] opc;
   logic [5:0] fn;
   logic [4:0] f_rt;
   logic [4:0] f_rd;

   assign opc  = instr[31:26];
   assign fn   = instr[5:0];
   assign f_rt = instr[20:16];
   assign f_rd = instr[15:11];

   always_comb begin
      ctl          = '0;
      ctl.alu_op   = ALU_ADD;
      unique case (opc)
         OPC_REG: begin
            ctl.dst = f_rd;
            unique case (fn)
               FN_ADD: begin
                  ctl.alu_op = ALU_ADD;
                  ctl.rf_we  = 1'b1;
                  ctl.ovf_en = 1'b1;
               end
               FN_SUB: begin
                  ctl.alu_op = ALU_SUB;
                  ctl.rf_we  = 1'b1;
                  ctl.ovf_en = 1'b1;
               end
               FN_SLL: begin
                  ctl.alu_op = ALU_SLL;
                  ctl.rf_we  = 1'b1;
               end
               default: ctl.illegal = 1'b1;
            endcase
         end
         OPC_ADDI: begin
            ctl.alu_op = ALU_ADD;
            ctl.b_imm  = 1'b1;
            ctl.rf_we  = 1'b1;
            ctl.ovf_en = 1'b1;
            ctl.dst    = f_rt;
         end
         OPC_ORI: begin
            ctl.alu_op   = ALU_OR;
            ctl.b_imm    = 1'b1;
            ctl.imm_zext = 1'b1;
            ctl.rf_we    = 1'b1;
            ctl.dst      = f_rt;
         end
         OPC_LUI: begin
            ctl.alu_op   = ALU_LUI;
            ctl.b_imm    = 1'b1;
            ctl.imm_zext = 1'b1;
            ctl.rf_we    = 1'b1;
            ctl.dst      = f_rt;
         end
         OPC_LOAD: begin
            ctl.rf_we  = 1'b1;
            ctl.wb_mem = 1'b1;
            ctl.dst    = f_rt;
         end
         OPC_STORE: begin
            ctl.mem_we = 1'b1;
         end
         default: ctl.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter  int XLEN     = 32,
   parameter  int NREG     = 32,
   parameter  bit STORE_R0 = 1'b0,
   localparam int AW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   ra,
   input  logic [AW-1:0]   rb,
   output logic [XLEN-1:0] qa,
   output logic [XLEN-1:0] qb
);

   generate
      if (STORE_R0) begin : g_full
         // entry zero is stored like any other and masked on the read side
         logic [XLEN-1:0] mem [NREG];
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
         assign qa = (ra == '0) ? '0 : mem[ra];
         assign qb = (rb == '0) ? '0 : mem[rb];
      end else begin : g_trim
         // entry zero has no storage and its write is dropped
         logic [XLEN-1:0] mem [1:NREG-1];
         always_ff @(posedge clk) begin
            if (we && waddr != '0) mem[waddr] <= wdata;
         end
         assign qa = (ra == '0) ? '0 : mem[ra];
         assign qb = (rb == '0) ? '0 : mem[rb];
      end
   endgenerate

   p_r0_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (ra == '0) |-> (qa == '0 && (rb != '0 || qb == '0)));

endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mini_core_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int SHW  = 5
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [SHW-1:0]  shamt,
   output logic [XLEN-1:0] y,
   output logic            ovf
);

   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] dif;

   assign sum = a + b;
   assign dif = a - b;

   always_comb begin
      y   = sum;
      ovf = 1'b0;
      unique case (op)
         ALU_ADD: begin
            y   = sum;
            ovf = (a[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
         end
         ALU_SUB: begin
            y   = dif;
            ovf = (a[XLEN-1] != b[XLEN-1]) && (dif[XLEN-1] != a[XLEN-1]);
         end
         ALU_SLL: y = b << shamt;
         ALU_OR:  y = a | b;
         ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
         default: y = sum;
      endcase
   end

endmodule

// File: rtl/mini_core.sv
module mini_core
   import mini_core_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              NREG     = 32,
   parameter int              PC_STEP  = 4,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter bit              STORE_R0 = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_data,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            ovf,
   output logic            illegal
);

   localparam int RAW = $clog2(NREG);
   localparam int IMW = 16;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mini_core: XLEN must be 32 for the fixed encoding");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("mini_core: NREG must be 32 to match 5-bit register fields");
      end
      if (PC_STEP <= 0 || (PC_STEP % 4) != 0) begin : g_bad_step
         $error("mini_core: PC_STEP must be a positive multiple of 4");
      end
   endgenerate

   logic [XLEN-1:0] pc_q;
   ctl_t            ctl;
   logic [XLEN-1:0] rs_d, rt_d, opb, imm_ext, imm_sx, alu_y, wb_data;
   logic            alu_ovf;
   logic [IMW-1:0]  imm;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= pc_q + XLEN'(PC_STEP);
   end
   assign imem_addr = pc_q;

   mc_decode u_dec (
      .instr (imem_data),
      .ctl   (ctl)
   );

   mc_regfile #(.XLEN(XLEN), .NREG(NREG), .STORE_R0(STORE_R0)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (ctl.rf_we & ~rst),
      .waddr (ctl.dst[RAW-1:0]),
      .wdata (wb_data),
      .ra    (imem_data[21 +: RAW]),
      .rb    (imem_data[16 +: RAW]),
      .qa    (rs_d),
      .qb    (rt_d)
   );

   assign imm     = imem_data[IMW-1:0];
   assign imm_sx  = {{(XLEN-IMW){imm[IMW-1]}}, imm};
   assign imm_ext = ctl.imm_zext ? {{(XLEN-IMW){1'b0}}, imm} : imm_sx;
   assign opb     = ctl.b_imm ? imm_ext : rt_d;

   mc_alu #(.XLEN(XLEN), .SHW(5)) u_alu (
      .op    (ctl.alu_op),
      .a     (rs_d),
      .b     (opb),
      .shamt (imem_data[10:6]),
      .y     (alu_y),
      .ovf   (alu_ovf)
   );

   // dedicated address adder, independent of the ALU
   assign dmem_addr  = rs_d + imm_sx;
   assign dmem_wdata = rt_d;
   assign dmem_we    = ctl.mem_we & ~rst;
   assign wb_data    = ctl.wb_mem ? dmem_rdata : alu_y;
   assign ovf        = ctl.ovf_en & alu_ovf;
   assign illegal    = ctl.illegal;

   p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (pc_q == $past(pc_q) + XLEN'(PC_STEP)));

   p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      illegal |-> (!dmem_we && !ctl.rf_we));

   p_ovf_arith_r9: assert property (@(posedge clk) disable iff (rst)
      ovf |-> (ctl.rf_we && (ctl.alu_op == ALU_ADD || ctl.alu_op == ALU_SUB)));

   p_lui_low_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (ctl.alu_op == ALU_LUI) |-> (alu_y[IMW-1:0] == '0));

   p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> !ctl.rf_we);

endmodule

// File: tb/sim_mini_core.sv
module sim_mini_core;

   localparam int CLK_PERIOD = 10;
   localparam int MEMW       = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, ovf, illegal;

   logic [31:0] imem [MEMW];
   logic [31:0] dmem [MEMW];
   logic        ovf_log [MEMW];
   logic        ill_log [MEMW];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mini_core u0 (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata),
      .ovf        (ovf),
      .illegal    (illegal)
   );

   assign imem_data  = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
   end

   always @(negedge clk) begin
      if (!rst) begin
         if (ovf)     ovf_log[imem_addr[7:2]] = 1'b1;
         if (illegal) ill_log[imem_addr[7:2]] = 1'b1;
      end
   end

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
   endfunction

   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic clear_all();
      rst = 1'b1;
      for (int i = 0; i < MEMW; i++) begin
         imem[i] = 32'h0;
         dmem[i] = 32'h0;
         ovf_log[i] = 1'b0;
         ill_log[i] = 1'b0;
      end
   endtask

   // reset, check reset state, then execute n instructions
   task automatic start_run(int n);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R8 reset pc", imem_addr, 32'h0);
      chk("R8 reset strobe", {31'd0, dmem_we}, 32'h0);
      rst = 1'b0;
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_pc_r8();
      clear_all();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R8 pc step", imem_addr, 32'(4 * k));
      end
   endtask

   task automatic t_arith_r1_r3();
      clear_all();
      imem[0] = enc_i(8, 0, 8, 5);
      imem[1] = enc_i(8, 0, 9, 7);
      imem[2] = 32'h01095020;
      imem[3] = enc_r(8, 9, 11, 0, 34);
      imem[4] = 32'h21090001;
      imem[5] = enc_i(8, 8, 12, -9);
      imem[6] = enc_i(43, 0, 10, 0);
      imem[7] = enc_i(43, 0, 11, 4);
      imem[8] = enc_i(43, 0, 9, 8);
      imem[9] = enc_i(43, 0, 12, 12);
      start_run(10);
      chk("R1 add word", dmem[0], 32'd12);
      chk("R1 sub", dmem[1], 32'hFFFFFFFE);
      chk("R3 addi word", dmem[2], 32'd6);
      chk("R3 addi negative", dmem[3], 32'hFFFFFFFC);
      chk("R9 no ovf on plain arith", {31'd0, ovf_log[2] | ovf_log[3] | ovf_log[5]}, 32'h0);
   endtask

   task automatic t_shift_r2();
      clear_all();
      imem[0] = enc_i(8, 0, 8, 3);
      imem[1] = 32'h00084080;
      imem[2] = enc_i(8, 0, 5, 1);
      imem[3] = enc_r(0, 5, 6, 31, 0);
      imem[4] = enc_i(43, 0, 8, 0);
      imem[5] = enc_i(43, 0, 6, 4);
      start_run(6);
      chk("R2 sll by 2", dmem[0], 32'd12);
      chk("R2 sll by 31", dmem[1], 32'h80000000);
   endtask

   task automatic t_const_r4_r5();
      clear_all();
      imem[0]  = enc_i(15, 0, 2, 16'h1234);
      imem[1]  = enc_i(13, 2, 2, 16'h5678);
      imem[2]  = enc_i(13, 0, 3, 16'h8000);
      imem[3]  = enc_i(8, 0, 7, -1);
      imem[4]  = enc_i(15, 7, 4, 16'hABCD);
      imem[5]  = enc_i(13, 4, 9, 16'h00F0);
      imem[6]  = enc_i(43, 0, 2, 0);
      imem[7]  = enc_i(43, 0, 3, 4);
      imem[8]  = enc_i(43, 0, 4, 8);
      imem[9]  = enc_i(43, 0, 9, 12);
      start_run(10);
      chk("R4 R5 built constant", dmem[0], 32'h12345678);
      chk("R4 zero extension", dmem[1], 32'h00008000);
      chk("R5 rs ignored", dmem[2], 32'hABCD0000);
      chk("R4 ori on upper", dmem[3], 32'hABCD00F0);
   endtask

   task automatic t_mem_r6();
      clear_all();
      dmem[30] = 32'hDEADBEEF;
      dmem[31] = 32'h0BADF00D;
      imem[0] = enc_i(8, 0, 8, 8);
      imem[1] = 32'h8d080070;
      imem[2] = enc_i(8, 0, 6, 200);
      imem[3] = enc_i(35, 6, 7, -76);
      imem[4] = enc_i(43, 0, 8, 0);
      imem[5] = enc_i(8, 0, 5, 64);
      imem[6] = enc_i(43, 5, 7, -4);
      start_run(7);
      chk("R6 load word", dmem[0], 32'hDEADBEEF);
      chk("R6 negative offsets", dmem[15], 32'h0BADF00D);
      chk("R6 load leaves memory", dmem[30], 32'hDEADBEEF);
   endtask

   task automatic t_zero_r7();
      clear_all();
      dmem[0]  = 32'hFFFFFFFF;
      dmem[1]  = 32'hFFFFFFFF;
      dmem[30] = 32'h55AA55AA;
      imem[0] = enc_i(8, 0, 0, 77);
      imem[1] = enc_i(35, 0, 0, 120);
      imem[2] = enc_r(0, 0, 1, 0, 32);
      imem[3] = enc_i(13, 0, 0, 16'hFFFF);
      imem[4] = enc_i(43, 0, 0, 0);
      imem[5] = enc_i(43, 0, 1, 4);
      start_run(6);
      chk("R7 reg0 store", dmem[0], 32'h0);
      chk("R7 reg0 as source", dmem[1], 32'h0);
   endtask

   task automatic t_ovf_r9();
      clear_all();
      imem[0]  = enc_i(15, 0, 8, 16'h7FFF);
      imem[1]  = enc_i(13, 8, 8, 16'hFFFF);
      imem[2]  = enc_i(8, 0, 9, 1);
      imem[3]  = enc_r(8, 9, 10, 0, 32);
      imem[4]  = enc_i(15, 0, 11, 16'h8000);
      imem[5]  = enc_r(11, 9, 12, 0, 34);
      imem[6]  = enc_r(8, 9, 13, 0, 34);
      imem[7]  = enc_i(8, 8, 14, 1);
      imem[8]  = enc_i(43, 0, 10, 0);
      imem[9]  = enc_i(43, 0, 12, 4);
      imem[10] = enc_i(43, 0, 13, 8);
      start_run(11);
      chk("R9 add ovf flag", {31'd0, ovf_log[3]}, 32'h1);
      chk("R9 sub ovf flag", {31'd0, ovf_log[5]}, 32'h1);
      chk("R9 sub no ovf", {31'd0, ovf_log[6]}, 32'h0);
      chk("R9 addi ovf flag", {31'd0, ovf_log[7]}, 32'h1);
      chk("R9 quiet on non-arith", {31'd0, ovf_log[0] | ovf_log[1] | ovf_log[4]}, 32'h0);
      chk("R9 add wraps", dmem[0], 32'h80000000);
      chk("R9 sub wraps", dmem[1], 32'h7FFFFFFF);
      chk("R9 sub result", dmem[2], 32'h7FFFFFFE);
   endtask

   task automatic t_illegal_r10();
      clear_all();
      dmem[2] = 32'h11111111;
      imem[0] = enc_i(8, 0, 12, 9);
      imem[1] = enc_r(12, 12, 12, 0, 33);
      imem[2] = enc_i(2, 0, 12, 16'h0040);
      imem[3] = enc_i(41, 0, 12, 8);
      imem[4] = enc_i(43, 0, 12, 0);
      start_run(5);
      chk("R10 flag on funct", {31'd0, ill_log[1]}, 32'h1);
      chk("R10 flag on opcode", {31'd0, ill_log[2] & ill_log[3]}, 32'h1);
      chk("R10 legal not flagged", {31'd0, ill_log[0] | ill_log[4]}, 32'h0);
      chk("R10 no register write", dmem[0], 32'd9);
      chk("R10 no memory write", dmem[2], 32'h11111111);
      chk("R10 pc still advances", imem_addr, 32'd20);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      clear_all();
      @(negedge clk);
      t_pc_r8();
      t_arith_r1_r3();
      t_shift_r2();
      t_const_r4_r5();
      t_mem_r6();
      t_zero_r7();
      t_ovf_r9();
      t_illegal_r10();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule